// File: doc/BRIEF.md
# Quad Double-Buffered DAC Load Controller

This block is the digital front end of a four-channel, 12-bit voltage-output converter. A host writes a 12-bit code for one channel into that channel's input register. It addresses the channel with a 2-bit selector and pulses chip select together with the input write strobe. A 12-bit host does this in one write with the byte-select line high. An 8-bit host uses two writes: the high byte first with byte-select high, then the low nibble, presented on the top four data lines, with byte-select low.

The staged codes go to the converter only on a transfer, which takes the transfer strobe and the transfer line low together. All four channel codes (DAC registers) then update in the same clock. A clear line gives two kinds of zeroing. On its own, it blanks all four output codes to zero while it is held low. The stored values come back when it rises. Together with a transfer, it wipes every DAC register to zero.

All control inputs are sampled on one clock. A write acts on the clock edge where its strobes are seen low. A write combined with a clear or a transfer is illegal: it raises an error flag and changes no register.

Top module: `qdac_load_ctrl`

## Requirements
- R1: After reset all four output codes are zero, `zero_force_o` and `err_o` are low, and every input register holds zero, so a transfer straight after reset still gives zero codes.
- R2: `chan_i` selects the channel: 0 is channel 0, 1 is channel 1, 2 is channel 2 and 3 is channel 3. Channel k is shown on `codes_o[12k+11:12k]`.
- R3: An input register changes only on a clock where `cs_n_i` and `wr_in_n_i` are both low. With either one high, no input register changes.
- R4: On a write with `byte_hi_i` high, the selected input register takes all of `data_i[11:0]`.
- R5: On a write with `byte_hi_i` low, bits 3:0 of the selected input register take `data_i[11:8]`, and bits 11:4 keep their value.
- R6: When `wr_xfer_n_i` and `xfer_n_i` are both low and `clr_n_i` is high, all four DAC registers copy their input registers on that clock. Input writes without a transfer leave `codes_o` unchanged.
- R7: When a transfer is sampled while `clr_n_i` is low, every DAC register becomes zero. The codes stay zero after `clr_n_i` rises, and the input registers are kept.
- R8: A sampled low on `clr_n_i` without a transfer sets `zero_force_o` and drives `codes_o` to zero on the next clock. The first clock that samples it high again restores the stored codes.
- R9: A write (`cs_n_i` and `wr_in_n_i` both low) sampled together with a clear or a transfer sets `err_o` on the next clock and leaves every input register, DAC register and `zero_force_o` unchanged. `err_o` is low after any other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_i | input | 12 | Write data |
| chan_i | input | 2 | Channel selector |
| cs_n_i | input | 1 | Chip select, active low |
| wr_in_n_i | input | 1 | Input-register write strobe, active low |
| byte_hi_i | input | 1 | 1: full-word write, 0: low-nibble write from data_i[11:8] |
| wr_xfer_n_i | input | 1 | Transfer strobe, active low |
| xfer_n_i | input | 1 | Transfer enable, active low |
| clr_n_i | input | 1 | Clear, active low |
| codes_o | output | 48 | Four 12-bit output codes, channel 0 in the low bits |
| zero_force_o | output | 1 | High while the outputs are blanked by clear |
| err_o | output | 1 | Illegal control combination seen on the previous clock |

## Verification
Input register contents cannot be seen at the ports until a transfer copies them out. Because of this, a nibble write that leaves the high byte unchanged, or a write that was inhibited, shows up only in a later transfer. The stimulus therefore follows every group of loads with a transfer. It also mixes split loads on different channels and inserts blank and wipe clears between them. The blank-then-restore case and the wipe case need the same input state to be examined before and after the clear. This is reached with directed sequences, and then with seeded random traffic compared against a bench model on every clock.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned CH_N_DEF = 4;
  localparam int unsigned DW_DEF   = 12;
  localparam int unsigned LO_W_DEF = 4;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_LOAD,
    ACT_XFER,
    ACT_WIPE,
    ACT_BLANK,
    ACT_BAD
  } act_e;
endpackage

// File: rtl/qdac_cmd_dec.sv
module qdac_cmd_dec
  import qdac_pkg::*;
#(
  parameter int unsigned CH_N = CH_N_DEF,
  localparam int unsigned AW = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic [AW-1:0]   chan_i,
  input  logic            cs_n_i,
  input  logic            wr_in_n_i,
  input  logic            wr_xfer_n_i,
  input  logic            xfer_n_i,
  input  logic            clr_n_i,
  output act_e            act_o,
  output logic [CH_N-1:0] sel_o
);
  logic wr_req, xf_req, cl_req;

  assign wr_req = ~cs_n_i & ~wr_in_n_i;
  assign xf_req = ~wr_xfer_n_i & ~xfer_n_i;
  assign cl_req = ~clr_n_i;

  always_comb begin
    if (wr_req && (xf_req || cl_req))  act_o = ACT_BAD;
    else if (wr_req)                   act_o = ACT_LOAD;
    else if (xf_req && cl_req)         act_o = ACT_WIPE;
    else if (xf_req)                   act_o = ACT_XFER;
    else if (cl_req)                   act_o = ACT_BLANK;
    else                               act_o = ACT_IDLE;
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_sel
    assign sel_o[g] = (chan_i == AW'(g));
  end
endmodule

// File: rtl/qdac_in_bank.sv
module qdac_in_bank
  import qdac_pkg::*;
#(
  parameter int unsigned CH_N = CH_N_DEF,
  parameter int unsigned DW   = DW_DEF,
  parameter int unsigned LO_W = LO_W_DEF
) (
  input  logic             clk,
  input  logic             arst_n,
  input  act_e             act_i,
  input  logic [CH_N-1:0]  sel_i,
  input  logic             full_i,
  input  logic [DW-1:0]    data_i,
  output logic [CH_N*DW-1:0] in_o
);
  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic [DW-1:0] in_q, in_nxt;
    logic          in_en;

    assign in_en = (act_i == ACT_LOAD) && sel_i[g];

    always_comb begin
      in_nxt = in_q;
      if (full_i) in_nxt = data_i;
      else        in_nxt[LO_W-1:0] = data_i[DW-1 -: LO_W];
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)    in_q <= '0;
      else if (in_en) in_q <= in_nxt;
    end

    assign in_o[g*DW +: DW] = in_q;
  end
endmodule

// File: rtl/qdac_out_bank.sv
module qdac_out_bank
  import qdac_pkg::*;
#(
  parameter int unsigned CH_N = CH_N_DEF,
  parameter int unsigned DW   = DW_DEF
) (
  input  logic               clk,
  input  logic               arst_n,
  input  act_e               act_i,
  input  logic [CH_N*DW-1:0] in_i,
  output logic [CH_N*DW-1:0] codes_o,
  output logic               zero_force_o
);
  logic [CH_N*DW-1:0] dac_q, dac_nxt;
  logic               dac_en;
  logic               zf_q, zf_nxt, zf_en;

  assign dac_en  = (act_i == ACT_XFER) || (act_i == ACT_WIPE);
  assign dac_nxt = (act_i == ACT_WIPE) ? '0 : in_i;
  assign zf_en   = (act_i != ACT_BAD);
  assign zf_nxt  = (act_i == ACT_BLANK) || (act_i == ACT_WIPE);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     dac_q <= '0;
    else if (dac_en) dac_q <= dac_nxt;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    zf_q <= 1'b0;
    else if (zf_en) zf_q <= zf_nxt;
  end

  assign codes_o      = zf_q ? '0 : dac_q;
  assign zero_force_o = zf_q;
endmodule

// File: rtl/qdac_load_ctrl.sv
module qdac_load_ctrl
  import qdac_pkg::*;
#(
  parameter int unsigned CH_N = CH_N_DEF,
  parameter int unsigned DW   = DW_DEF,
  parameter int unsigned LO_W = LO_W_DEF,
  localparam int unsigned AW = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      data_i,
  input  logic [AW-1:0]      chan_i,
  input  logic               cs_n_i,
  input  logic               wr_in_n_i,
  input  logic               byte_hi_i,
  input  logic               wr_xfer_n_i,
  input  logic               xfer_n_i,
  input  logic               clr_n_i,
  output logic [CH_N*DW-1:0] codes_o,
  output logic               zero_force_o,
  output logic               err_o
);
  logic               rst_meta_q, arst_n;
  act_e               act;
  logic [CH_N-1:0]    sel;
  logic [CH_N*DW-1:0] in_flat;
  logic               err_q, err_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      arst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      arst_n     <= rst_meta_q;
    end
  end

  qdac_cmd_dec #(.CH_N(CH_N)) u_dec (
    .chan_i      (chan_i),
    .cs_n_i      (cs_n_i),
    .wr_in_n_i   (wr_in_n_i),
    .wr_xfer_n_i (wr_xfer_n_i),
    .xfer_n_i    (xfer_n_i),
    .clr_n_i     (clr_n_i),
    .act_o       (act),
    .sel_o       (sel)
  );

  qdac_in_bank #(.CH_N(CH_N), .DW(DW), .LO_W(LO_W)) u_in (
    .clk    (clk),
    .arst_n (arst_n),
    .act_i  (act),
    .sel_i  (sel),
    .full_i (byte_hi_i),
    .data_i (data_i),
    .in_o   (in_flat)
  );

  qdac_out_bank #(.CH_N(CH_N), .DW(DW)) u_out (
    .clk          (clk),
    .arst_n       (arst_n),
    .act_i        (act),
    .in_i         (in_flat),
    .codes_o      (codes_o),
    .zero_force_o (zero_force_o)
  );

  assign err_nxt = (act == ACT_BAD);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) err_q <= 1'b0;
    else         err_q <= err_nxt;
  end

  assign err_o = err_q;
endmodule

// File: rtl/qdac_load_ctrl_chk.sv
module qdac_load_ctrl_chk #(
  parameter int unsigned CH_N = 4,
  parameter int unsigned DW   = 12
) (
  input logic               clk,
  input logic               arst_n,
  input logic               cs_n_i,
  input logic               wr_in_n_i,
  input logic               wr_xfer_n_i,
  input logic               xfer_n_i,
  input logic               clr_n_i,
  input logic [CH_N*DW-1:0] codes_o,
  input logic               zero_force_o,
  input logic               err_o
);
  // R9
  bad_combo_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!cs_n_i && !wr_in_n_i && (!clr_n_i || (!wr_xfer_n_i && !xfer_n_i)))
    |=> (err_o && $stable(codes_o) && $stable(zero_force_o)));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cs_n_i || wr_in_n_i) |=> !err_o);

  // R8
  blank_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!clr_n_i && (cs_n_i || wr_in_n_i)) |=> (zero_force_o && codes_o == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ((cs_n_i || wr_in_n_i) && (wr_xfer_n_i || xfer_n_i) && clr_n_i && !zero_force_o)
    |=> ($stable(codes_o) && !zero_force_o));

  // R6
  xfer_unblank_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!wr_xfer_n_i && !xfer_n_i && clr_n_i && (cs_n_i || wr_in_n_i))
    |=> !zero_force_o);
endmodule

bind qdac_load_ctrl qdac_load_ctrl_chk #(.CH_N(CH_N), .DW(DW)) u_chk (
  .clk          (clk),
  .arst_n       (arst_n),
  .cs_n_i       (cs_n_i),
  .wr_in_n_i    (wr_in_n_i),
  .wr_xfer_n_i  (wr_xfer_n_i),
  .xfer_n_i     (xfer_n_i),
  .clr_n_i      (clr_n_i),
  .codes_o      (codes_o),
  .zero_force_o (zero_force_o),
  .err_o        (err_o)
);

// File: tb/qdac_load_ctrl_test.sv
module qdac_load_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic [11:0] data_i;
  logic [1:0]  chan_i;
  logic        cs_n_i, wr_in_n_i, byte_hi_i, wr_xfer_n_i, xfer_n_i, clr_n_i;
  logic [47:0] codes_o;
  logic        zero_force_o, err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [11:0] m_in  [4];
  logic [11:0] m_dac [4];
  logic        m_zf, m_err;

  qdac_load_ctrl uut (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .chan_i(chan_i),
    .cs_n_i(cs_n_i), .wr_in_n_i(wr_in_n_i), .byte_hi_i(byte_hi_i),
    .wr_xfer_n_i(wr_xfer_n_i), .xfer_n_i(xfer_n_i), .clr_n_i(clr_n_i),
    .codes_o(codes_o), .zero_force_o(zero_force_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [47:0] exp_codes();
    logic [47:0] v;
    for (int k = 0; k < 4; k++) v[k*12 +: 12] = m_zf ? 12'h000 : m_dac[k];
    return v;
  endfunction

  task automatic check(input string tag);
    logic [47:0] e;
    e = exp_codes();
    total++;
    if (codes_o !== e || zero_force_o !== m_zf || err_o !== m_err) begin
      bad++;
      $display("FAIL %s: codes=%h zf=%b err=%b expected codes=%h zf=%b err=%b",
               tag, codes_o, zero_force_o, err_o, e, m_zf, m_err);
    end
  endtask

  task automatic set_idle();
    cs_n_i = 1; wr_in_n_i = 1; byte_hi_i = 1; wr_xfer_n_i = 1;
    xfer_n_i = 1; clr_n_i = 1; chan_i = 0; data_i = 0;
  endtask

  // drive at a negedge, model the clock edge, compare at the next negedge
  task automatic step(input bit cs, input bit w1, input bit bh, input bit w2,
                      input bit xf, input bit cl, input logic [1:0] ch,
                      input logic [11:0] d, input string tag);
    bit ld, tr, cr;
    cs_n_i = cs; wr_in_n_i = w1; byte_hi_i = bh; wr_xfer_n_i = w2;
    xfer_n_i = xf; clr_n_i = cl; chan_i = ch; data_i = d;
    ld = !cs && !w1; tr = !w2 && !xf; cr = !cl;
    if (ld && (tr || cr)) m_err = 1;
    else begin
      m_err = 0;
      if (ld) begin
        if (bh) m_in[ch] = d;
        else    m_in[ch][3:0] = d[11:8];
      end
      if (tr) for (int k = 0; k < 4; k++) m_dac[k] = cr ? 12'h000 : m_in[k];
      m_zf = cr;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input string tag);
    step(1, 1, 1, 1, 1, 1, 0, 12'h000, tag);
  endtask
  task automatic wr_full(input logic [1:0] ch, input logic [11:0] d, input string tag);
    step(0, 0, 1, 1, 1, 1, ch, d, tag);
  endtask
  task automatic wr_nib(input logic [1:0] ch, input logic [11:0] d, input string tag);
    step(0, 0, 0, 1, 1, 1, ch, d, tag);
  endtask
  task automatic xfer(input string tag);
    step(1, 1, 1, 0, 0, 1, 0, 12'h000, tag);
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    set_idle();
    for (int k = 0; k < 4; k++) begin m_in[k] = 0; m_dac[k] = 0; end
    m_zf = 0; m_err = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    check("R1 reset state");
    xfer("R1 transfer after reset gives zero");

    // R4 full-word loads on each channel, R6 no effect before transfer
    wr_full(0, 12'h123, "R6 load ch0 no output change");
    wr_full(1, 12'h456, "R6 load ch1 no output change");
    wr_full(2, 12'h789, "R6 load ch2 no output change");
    wr_full(3, 12'hABC, "R6 load ch3 no output change");
    xfer("R2 R4 R6 transfer all four channels");

    // R5 split load on 8-bit bus
    wr_full(2, 12'hE70, "R5 high byte write");
    wr_nib(2, 12'h5C3, "R5 nibble write from top lines");
    xfer("R5 split load result");
    wr_nib(0, 12'hF00, "R5 nibble only keeps upper bits");
    xfer("R5 upper bits preserved");

    // R3 inhibit
    step(1, 0, 1, 1, 1, 1, 1, 12'hFFF, "R3 cs high inhibits");
    step(0, 1, 1, 1, 1, 1, 1, 12'hFFF, "R3 wr high inhibits");
    xfer("R3 input unchanged after inhibited writes");

    // R8 blank and restore
    step(1, 1, 1, 1, 1, 0, 0, 12'h000, "R8 blank active");
    step(1, 1, 1, 1, 1, 0, 0, 12'h000, "R8 blank held");
    idle("R8 codes restored");

    // R7 wipe
    wr_full(3, 12'h3D1, "R7 stage new ch3");
    step(1, 1, 1, 0, 0, 0, 0, 12'h000, "R7 wipe with transfer");
    idle("R7 codes remain zero after clear release");
    xfer("R7 input registers kept through wipe");

    // R9 illegal combinations
    step(0, 0, 1, 0, 0, 1, 1, 12'h999, "R9 write with transfer");
    step(0, 0, 1, 1, 1, 0, 2, 12'h888, "R9 write with clear");
    idle("R9 error clears");
    xfer("R9 no input changed by illegal writes");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit cs, w1, bh, w2, xf, cl;
      int r;
      r  = $urandom % 100;
      cs = !(r < 55); w1 = !(r < 60);
      bh = ($urandom % 2) == 0;
      r  = $urandom % 100;
      w2 = !(r < 25); xf = !(r < 20 || ($urandom % 4 == 0));
      cl = !($urandom % 100 < 12);
      step(cs, w1, bh, w2, xf, cl, 2'($urandom % 4), 12'($urandom), "R2 random traffic");
    end

    set_idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule